// File: doc/BRIEF.md
# Two-Requester Bus Grant Pair with Valid-Gating Controller

This block hands a shared bus to one of two requesters. The work is split between two cooperating machines. A controller watches the requests, the bus-free flag, the lock flag and the arbiter's busy line, and it drives a single registered valid line. An arbiter watches the requests, the device-ready flag and valid, and it issues one-cycle grants. A grant can only follow a cycle in which valid was already high. The controller therefore has to decide one cycle early whether a grant is allowed.

The lock flag stops the controller from arming valid for requester 1. When lock is high and requester 0 is not asking, valid stays low. Requester 0 may still be served while lock is high. Busy mirrors the grants, and a grant never lasts more than one cycle. While busy is high the arbiter schedules nothing, so the cycle after a grant is always idle. The two requests are assumed never to be high together.

The asynchronous active-low reset is released through a small synchroniser. The outputs therefore stay in their reset values for two rising edges after reset is released.

Top module: `bus_grant_pair`

## Requirements
- R1: If req0 is high, busy is low and bus_free is high in a cycle, valid is high in the next cycle, whatever the value of lock.
- R2: If req1 is high, req0 is low, lock is low, busy is low and bus_free is high in a cycle, valid is high in the next cycle.
- R3: If lock is high and req0 is low in a cycle, valid is low in the next cycle, even while req1 is asking.
- R4: valid is high only in a cycle that follows a cycle meeting the R1 or R2 condition. With no request, with busy high, or with bus_free low, valid is low in the next cycle.
- R5: If busy is low and req0, valid and dev_rdy are all high in a cycle, grant0 is high in the next cycle. The same rule links req1 to grant1.
- R6: A grant is high only in a cycle that follows a cycle where valid, dev_rdy and the matching request were all high. Without valid or dev_rdy there is no grant.
- R7: busy is high exactly when grant0 or grant1 is high, and the two grants are never high together.
- R8: busy is never high in two consecutive cycles. During a busy cycle, requests, valid and dev_rdy are ignored, and no grant appears in the following cycle.
- R9: While rst_n is low, and for the first rising edge after it is released, valid, grant0, grant1 and busy are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req0 | input | 1 | Request from requester 0 |
| req1 | input | 1 | Request from requester 1 (never high together with req0) |
| lock | input | 1 | Bus lock flag; blocks valid unless req0 is asking |
| dev_rdy | input | 1 | Target device ready |
| bus_free | input | 1 | Bus is free for a new transfer |
| grant0 | output | 1 | One-cycle grant to requester 0 |
| grant1 | output | 1 | One-cycle grant to requester 1 |
| busy | output | 1 | High in any grant cycle |
| valid | output | 1 | Controller's registered enable toward the arbiter |

## Verification
The two functions that collide are the controller re-arming valid and the arbiter's busy suppression. In the grant cycle, valid is still high because it was computed before busy rose. A request that persists with dev_rdy high in that cycle would, by the bare grant rule, demand a second grant. The benches provoke this by holding req1, dev_rdy and bus_free through a grant. They then check that the next cycle carries no grant and a low valid, and that the grant after that comes only after valid has been re-armed. A second collision comes from the lock sequence. req0 is swapped for req1 under lock in the same cycle as the grant, and the bench checks that valid falls and no grant1 follows.

// File: rtl/bga_pkg.sv
package bga_pkg;

  typedef enum logic {
    CTL_HOLD  = 1'b0,
    CTL_ARMED = 1'b1
  } ctl_state_e;

  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_GNT0 = 2'd1,
    ARB_GNT1 = 2'd2
  } arb_state_e;

  localparam int unsigned NUM_REQ = 2;

endpackage

// File: rtl/bga_rst_sync.sv
module bga_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) chain_q <= 1'b0;
        else              chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n_async) begin
        if (!rst_n_async) chain_q <= '0;
        else              chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[LAST];

endmodule

// File: rtl/bga_valid_ctl.sv
module bga_valid_ctl
  import bga_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req0,
  input  logic req1,
  input  logic lock,
  input  logic bus_free,
  input  logic busy,
  output logic valid
);

  ctl_state_e state_q, state_d;
  logic       slot_open;
  logic       want_arm;
  logic       upd_en;

  // Arming needs an open slot; requester 1 is additionally blocked by lock.
  always_comb begin
    slot_open = bus_free & ~busy;
    want_arm  = slot_open & (req0 | (req1 & ~lock));
    state_d   = want_arm ? CTL_ARMED : CTL_HOLD;
    upd_en    = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= CTL_HOLD;
    else if (upd_en) state_q <= state_d;
  end

  assign valid = (state_q == CTL_ARMED);

  // R1
  r0_arms_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req0 && !busy && bus_free) |=> valid);

  // R2
  r1_arms_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req1 && !req0 && !lock && !busy && bus_free) |=> valid);

  // R3
  lock_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !req0) |=> !valid);

  // R4
  busy_drops_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || !bus_free || (!req0 && !req1)) |=> !valid);

endmodule

// File: rtl/bga_arbiter.sv
module bga_arbiter
  import bga_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req0,
  input  logic req1,
  input  logic dev_rdy,
  input  logic valid,
  output logic grant0,
  output logic grant1,
  output logic busy
);

  arb_state_e state_q, state_d;
  logic       go;
  logic       upd_en;

  always_comb begin
    go      = valid & dev_rdy;
    state_d = ARB_IDLE;
    unique case (state_q)
      ARB_IDLE: begin
        if (go && req0)      state_d = ARB_GNT0;
        else if (go && req1) state_d = ARB_GNT1;
        else                 state_d = ARB_IDLE;
      end
      // a grant cycle is always followed by an idle cycle
      ARB_GNT0, ARB_GNT1: state_d = ARB_IDLE;
      default:            state_d = ARB_IDLE;
    endcase
    upd_en = (state_d != state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= ARB_IDLE;
    else if (upd_en) state_q <= state_d;
  end

  assign grant0 = (state_q == ARB_GNT0);
  assign grant1 = (state_q == ARB_GNT1);
  assign busy   = (state_q != ARB_IDLE);

  // R5
  grant0_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req0 && valid && dev_rdy && !busy) |=> grant0);

  // R5
  grant1_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req1 && valid && dev_rdy && !busy) |=> grant1);

  // R6
  grant0_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant0 |-> $past(req0 && valid && dev_rdy));

  // R6
  grant1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant1 |-> $past(req1 && valid && dev_rdy));

  // R7
  busy_is_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (grant0 || grant1));

  // R7
  grant_mutex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({grant0, grant1}));

  // R8
  busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

endmodule

// File: rtl/bus_grant_pair.sv
module bus_grant_pair
  import bga_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req0,
  input  logic req1,
  input  logic lock,
  input  logic dev_rdy,
  input  logic bus_free,
  output logic grant0,
  output logic grant1,
  output logic busy,
  output logic valid
);

  logic rst_n_int;
  logic busy_w;
  logic valid_w;

  bga_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_int)
  );

  bga_valid_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req0     (req0),
    .req1     (req1),
    .lock     (lock),
    .bus_free (bus_free),
    .busy     (busy_w),
    .valid    (valid_w)
  );

  bga_arbiter u_arb (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .req0    (req0),
    .req1    (req1),
    .dev_rdy (dev_rdy),
    .valid   (valid_w),
    .grant0  (grant0),
    .grant1  (grant1),
    .busy    (busy_w)
  );

  assign busy  = busy_w;
  assign valid = valid_w;

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (!valid && !grant0 && !grant1 && !busy));

endmodule

// File: tb/tb_bus_grant_pair.sv
`timescale 1ns/1ps
module tb_bus_grant_pair;

  logic clk = 1'b0;
  logic rst_n, req0, req1, lock, dev_rdy, bus_free;
  logic grant0, grant1, busy, valid;
  int   checks = 0;
  int   errors = 0;

  always #10 clk = ~clk;

  bus_grant_pair dut (
    .clk(clk), .rst_n(rst_n), .req0(req0), .req1(req1), .lock(lock),
    .dev_rdy(dev_rdy), .bus_free(bus_free), .grant0(grant0),
    .grant1(grant1), .busy(busy), .valid(valid)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic r0, input logic r1, input logic lk,
                       input logic rdy, input logic bf);
    req0 = r0; req1 = r1; lock = lk; dev_rdy = rdy; bus_free = bf;
  endtask

  task automatic settle();
    drive(0, 0, 0, 0, 0);
    tick(); tick(); tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(1, 0, 0, 1, 1);
    tick(); tick();
    chk("R9", "valid in reset", valid, 1'b0);
    chk("R9", "busy in reset", busy, 1'b0);
    chk("R9", "grant0 in reset", grant0, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R9", "valid first edge after release", valid, 1'b0);
    chk("R9", "grant1 first edge after release", grant1, 1'b0);
    settle();
  endtask

  task automatic t_locked_swap();
    drive(1, 0, 1, 1, 1);
    tick();
    chk("R1", "valid for req0 under lock", valid, 1'b1);
    chk("R6", "no grant before valid seen", grant0, 1'b0);
    tick();
    chk("R5", "grant0", grant0, 1'b1);
    chk("R7", "busy with grant0", busy, 1'b1);
    chk("R7", "grant1 low with grant0", grant1, 1'b0);
    chk("R1", "valid still high in grant cycle", valid, 1'b1);
    drive(0, 1, 1, 1, 1);
    tick();
    chk("R3", "valid low after lock without req0", valid, 1'b0);
    chk("R8", "busy drops after one cycle", busy, 1'b0);
    chk("R8", "no grant1 from busy cycle", grant1, 1'b0);
    tick();
    chk("R3", "valid stays low for req1 under lock", valid, 1'b0);
    chk("R6", "no grant1 without valid", grant1, 1'b0);
    settle();
  endtask

  task automatic t_unlocked_r1_repeat();
    drive(0, 1, 0, 1, 1);
    tick();
    chk("R2", "valid for req1 unlocked", valid, 1'b1);
    tick();
    chk("R5", "grant1", grant1, 1'b1);
    chk("R7", "busy with grant1", busy, 1'b1);
    chk("R7", "grant0 low with grant1", grant0, 1'b0);
    tick();
    chk("R8", "no back-to-back grant1", grant1, 1'b0);
    chk("R8", "busy not consecutive", busy, 1'b0);
    chk("R4", "valid low after busy cycle", valid, 1'b0);
    tick();
    chk("R2", "valid re-armed", valid, 1'b1);
    chk("R6", "no grant while valid was low", grant1, 1'b0);
    tick();
    chk("R5", "second grant1", grant1, 1'b1);
    settle();
  endtask

  task automatic t_bus_not_free();
    drive(1, 0, 0, 1, 0);
    tick();
    chk("R4", "valid low with bus not free", valid, 1'b0);
    tick();
    chk("R6", "no grant0 with bus not free", grant0, 1'b0);
    settle();
  endtask

  task automatic t_not_ready();
    drive(1, 0, 0, 0, 1);
    tick();
    chk("R1", "valid without dev_rdy", valid, 1'b1);
    tick();
    chk("R6", "no grant0 without dev_rdy", grant0, 1'b0);
    chk("R6", "busy low without dev_rdy", busy, 1'b0);
    settle();
  endtask

  task automatic t_idle();
    drive(0, 0, 1, 1, 1);
    tick();
    chk("R4", "valid low with no request", valid, 1'b0);
    chk("R7", "busy low when idle", busy, 1'b0);
    settle();
  endtask

  initial begin
    drive(0, 0, 0, 0, 0);
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_locked_swap();
    t_unlocked_r1_repeat();
    t_bus_not_free();
    t_not_ready();
    t_idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule